// File: doc/BRIEF.md
# Single-Bit Fuse Programming Sequencer

This block steps a one-time-programmable fuse memory through the timed sequence that blows a single fuse and then reads the word back. A request names one word address, one bit position and the data word the location should hold afterwards. The sequencer latches the request and addresses the word. It pulls the chip enable low and turns the outputs off. It drops the program enable and raises the supply-select line to request the programming voltage. It then pulls exactly one data line low for the pulse width. After that it lowers the supply, restores program enable and the output drivers, and compares the word on the data bus with the expected value.

Each interval is a parameter counted in clock cycles: the settle delay TD, the supply rise TR, the fuse pulse TPW and the supply fall TF. A mismatch at read-back sets a sticky reject flag, which stays set until a clear input is raised. Only one request is in flight at a time. A start strobe seen while the sequencer is busy is dropped.

Top module: `fuse_prog_seq`

## Requirements
- R1: After reset the block is idle: chip enable high, output enable low, program enable high, supply select low, no pull-down line active, busy, done and reject all low, and the address output zero.
- R2: A start strobe while idle latches the address, the bit index and the expected word. Busy is high from the next cycle, and the address output then shows the latched address.
- R3: After the start edge the phases run in this order, one after the other: setup TD cycles (E high, G low, P high); access TD (E low); output off TD (G high); program low TD (P low); supply rise TR (select high); settle TD; pulse TPW; release TD; supply fall TF (select low); program high TD (P high, G still high); output on TD (G low); check 1 cycle.
- R4: The pull-down bus is one-hot with bit number equal to the latched bit index, and only during the pulse phase. At all other times it is zero. It is never active unless supply select is high and program enable is low.
- R5: Supply select is high only while program enable is low and the outputs are off.
- R6: Chip enable stays low from the access phase through the check cycle, and the address output does not change while busy.
- R7: Done is high for exactly the check cycle. Busy falls in the following cycle.
- R8: In the check cycle the data bus is compared with the latched expected word. Any difference sets reject from the next cycle. A match leaves reject as it was.
- R9: Reject stays set until clear is high at a clock edge. A mismatch in the same cycle as clear takes precedence, and reject stays set.
- R10: A start strobe while busy is ignored. The phase timing, the pin sequence and the address output are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe |
| clr_rej_i | input | 1 | Clears the reject flag |
| addr_i | input | 11 | Word address to program |
| bit_i | input | 3 | Bit position to blow |
| exp_i | input | 8 | Expected word after programming |
| rd_data_i | input | 8 | Data bus from the fuse memory |
| addr_o | output | 11 | Address to the fuse memory |
| ce_n_o | output | 1 | Chip enable, low active |
| oe_n_o | output | 1 | Output enable, low active |
| pe_o | output | 1 | Program enable, low selects programming |
| vsel_o | output | 1 | High requests the programming supply |
| pull_lo_o | output | 8 | Per-bit pull-down controls |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Pulse in the check cycle |
| reject_o | output | 1 | Sticky read-back failure |

## Verification
The start strobe is captured at a clock edge. The first setup cycle is the cycle after that edge, and each phase boundary follows by the cumulative sum of the phase lengths. With the bench settings TD=3, TR=5, TPW=7 and TF=4, done is due in cycle 41 after the capture edge, and the change on reject and busy is due in cycle 42. The bench counts elapsed cycles from the capture edge. It samples every output on the falling edge of each of those cycles against a phase table it computes itself, and it checks reject and the idle pins one cycle after done. Clear and stray start strobes are driven on a falling edge, and their effect is checked at the next falling edge.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_SETUP, PH_ACCESS, PH_OEOFF, PH_PLOW, PH_RISE, PH_SETTLE,
    PH_PULSE, PH_RELEASE, PH_FALL, PH_PHIGH, PH_OEON, PH_CHECK
  } fps_phase_e;

  function automatic fps_phase_e fps_next(input fps_phase_e ph);
    case (ph)
      PH_SETUP:   return PH_ACCESS;
      PH_ACCESS:  return PH_OEOFF;
      PH_OEOFF:   return PH_PLOW;
      PH_PLOW:    return PH_RISE;
      PH_RISE:    return PH_SETTLE;
      PH_SETTLE:  return PH_PULSE;
      PH_PULSE:   return PH_RELEASE;
      PH_RELEASE: return PH_FALL;
      PH_FALL:    return PH_PHIGH;
      PH_PHIGH:   return PH_OEON;
      PH_OEON:    return PH_CHECK;
      default:    return PH_IDLE;
    endcase
  endfunction

  function automatic int fps_len(input fps_phase_e ph, input int td,
                                 input int tr, input int tpw, input int tf);
    case (ph)
      PH_RISE:  return tr;
      PH_PULSE: return tpw;
      PH_FALL:  return tf;
      PH_CHECK: return 1;
      PH_IDLE:  return 1;
      default:  return td;
    endcase
  endfunction

endpackage

// File: rtl/fps_phase_timer.sv
module fps_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/fps_pin_decode.sv
module fps_pin_decode
  import fps_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input  fps_phase_e        ph_i,
  input  logic [BIT_W-1:0]  bit_i,
  output logic              ce_n_o,
  output logic              oe_n_o,
  output logic              pe_o,
  output logic              vsel_o,
  output logic [DATA_W-1:0] pull_lo_o
);
  logic pulse_w;

  always_comb begin
    ce_n_o = (ph_i == PH_IDLE) || (ph_i == PH_SETUP);
    oe_n_o = (ph_i >= PH_OEOFF) && (ph_i <= PH_PHIGH);
    pe_o   = !((ph_i >= PH_PLOW) && (ph_i <= PH_FALL));
    vsel_o = (ph_i >= PH_RISE) && (ph_i <= PH_RELEASE);
  end

  assign pulse_w = (ph_i == PH_PULSE);

  for (genvar g = 0; g < DATA_W; g++) begin : g_pull
    assign pull_lo_o[g] = pulse_w && (bit_i == BIT_W'(g));
  end
endmodule

// File: rtl/fps_verify.sv
module fps_verify #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              check_i,
  input  logic [DATA_W-1:0] rd_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic              clr_i,
  output logic              mismatch_o,
  output logic              reject_o
);
  assign mismatch_o = check_i && (rd_i != exp_i);

  always_ff @(posedge clk) begin
    if (!rst_n)          reject_o <= 1'b0;
    else if (mismatch_o) reject_o <= 1'b1;
    else if (clr_i)      reject_o <= 1'b0;
  end
endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
  import fps_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int TD     = 100,
  parameter int TR     = 1000,
  parameter int TPW    = 10000,
  parameter int TF     = 1000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic                        clr_rej_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [$clog2(DATA_W)-1:0]   bit_i,
  input  logic [DATA_W-1:0]           exp_i,
  input  logic [DATA_W-1:0]           rd_data_i,
  output logic [ADDR_W-1:0]           addr_o,
  output logic                        ce_n_o,
  output logic                        oe_n_o,
  output logic                        pe_o,
  output logic                        vsel_o,
  output logic [DATA_W-1:0]           pull_lo_o,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        reject_o
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int MAXD  = (TPW > TR ? (TPW > TF ? TPW : TF) : (TR > TF ? TR : TF)) > TD
                       ? (TPW > TR ? (TPW > TF ? TPW : TF) : (TR > TF ? TR : TF)) : TD;
  localparam int CW    = $clog2(MAXD + 1);

  fps_phase_e        ph_q, ph_nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] exp_q;
  logic              start_acc, expired, phase_end, load_w, mismatch;
  logic [CW-1:0]     len_w;
  int                len_int;

  assign start_acc = (ph_q == PH_IDLE) && start_i;
  assign phase_end = (ph_q != PH_IDLE) && expired;
  assign load_w    = start_acc || phase_end;
  assign ph_nxt    = start_acc ? PH_SETUP : fps_next(ph_q);
  assign len_int   = fps_len(ph_nxt, TD, TR, TPW, TF) - 1;
  assign len_w     = len_int[CW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      addr_q <= '0;
      bit_q  <= '0;
      exp_q  <= '0;
    end else begin
      if (load_w) ph_q <= ph_nxt;
      if (start_acc) begin
        addr_q <= addr_i;
        bit_q  <= bit_i;
        exp_q  <= exp_i;
      end
    end
  end

  fps_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .len_i(len_w), .expired_o(expired)
  );

  fps_pin_decode #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_pins (
    .ph_i(ph_q), .bit_i(bit_q), .ce_n_o(ce_n_o), .oe_n_o(oe_n_o),
    .pe_o(pe_o), .vsel_o(vsel_o), .pull_lo_o(pull_lo_o)
  );

  fps_verify #(.DATA_W(DATA_W)) u_verify (
    .clk(clk), .rst_n(rst_n), .check_i(ph_q == PH_CHECK), .rd_i(rd_data_i),
    .exp_i(exp_q), .clr_i(clr_rej_i), .mismatch_o(mismatch), .reject_o(reject_o)
  );

  assign addr_o = addr_q;
  assign busy_o = (ph_q != PH_IDLE);
  assign done_o = (ph_q == PH_CHECK);
endmodule

// File: rtl/fps_chk.sv
module fps_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_rej_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              ce_n_o,
  input logic              oe_n_o,
  input logic              pe_o,
  input logic              vsel_o,
  input logic [DATA_W-1:0] pull_lo_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              reject_o,
  input logic              phase_end,
  input logic              mismatch
);
  AST_PULL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pull_lo_o)); // R4
  AST_PULL_GATED: assert property (@(posedge clk) disable iff (!rst_n) (|pull_lo_o) |-> (vsel_o && !pe_o && !ce_n_o)); // R4
  AST_VSEL_SAFE: assert property (@(posedge clk) disable iff (!rst_n) vsel_o |-> (!pe_o && oe_n_o)); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && $past(busy_o)) |-> $stable(addr_o)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> (!done_o && !busy_o)); // R7
  AST_DONE_ENDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> phase_end); // R7
  AST_REJ_SET: assert property (@(posedge clk) disable iff (!rst_n) mismatch |=> reject_o); // R8
  AST_REJ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) $rose(reject_o) |-> $past(done_o)); // R8
  AST_REJ_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (reject_o && !clr_rej_i) |=> reject_o); // R9
endmodule

bind fuse_prog_seq fps_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fps_chk (
  .clk(clk), .rst_n(rst_n), .clr_rej_i(clr_rej_i), .addr_o(addr_o),
  .ce_n_o(ce_n_o), .oe_n_o(oe_n_o), .pe_o(pe_o), .vsel_o(vsel_o),
  .pull_lo_o(pull_lo_o), .busy_o(busy_o), .done_o(done_o), .reject_o(reject_o),
  .phase_end(phase_end), .mismatch(mismatch)
);

// File: tb/fuse_prog_seq_tb_top.sv
module fuse_prog_seq_tb_top;
  localparam int TD = 3, TR = 5, TPW = 7, TF = 4;
  localparam int TOTAL = 8 * TD + TR + TPW + TF + 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start_i = 1'b0, clr_rej_i = 1'b0;
  logic [10:0] addr_i = '0;
  logic [2:0]  bit_i = '0;
  logic [7:0]  exp_i = '0;
  logic [7:0]  rd_data_i;
  logic [10:0] addr_o;
  logic        ce_n_o, oe_n_o, pe_o, vsel_o, busy_o, done_o, reject_o;
  logic [7:0]  pull_lo_o;

  int checks = 0, failures = 0;
  logic [7:0] mem [2048];
  logic fault_en = 1'b0;
  logic rej_model = 1'b0;

  always #5 clk = ~clk;

  fuse_prog_seq #(.TD(TD), .TR(TR), .TPW(TPW), .TF(TF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .clr_rej_i(clr_rej_i),
    .addr_i(addr_i), .bit_i(bit_i), .exp_i(exp_i), .rd_data_i(rd_data_i),
    .addr_o(addr_o), .ce_n_o(ce_n_o), .oe_n_o(oe_n_o), .pe_o(pe_o),
    .vsel_o(vsel_o), .pull_lo_o(pull_lo_o), .busy_o(busy_o), .done_o(done_o),
    .reject_o(reject_o)
  );

  // Fuse memory model: blows a fuse when the programming conditions hold.
  assign rd_data_i = (!ce_n_o && !oe_n_o) ? mem[addr_o] : 8'hFF;
  always @(posedge clk)
    if (vsel_o && !pe_o && (|pull_lo_o) && !fault_en) mem[addr_o] <= mem[addr_o] | pull_lo_o;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Phase index at elapsed cycle n (1-based after capture edge).
  function automatic int phase_at(input int n);
    int lens[12] = '{TD, TD, TD, TD, TR, TD, TPW, TD, TF, TD, TD, 1};
    int acc = 0;
    for (int i = 0; i < 12; i++) begin
      acc += lens[i];
      if (n <= acc) return i;
    end
    return 12;
  endfunction

  function automatic logic [3:0] pins_for(input int ph); // {E, G, P, SEL}
    logic e, g, p, s;
    e = (ph == 0);
    g = (ph >= 2 && ph <= 9);
    p = !(ph >= 3 && ph <= 8);
    s = (ph >= 4 && ph <= 7);
    return {e, g, p, s};
  endfunction

  task automatic run_op(input logic [10:0] a, input logic [2:0] b, input logic [7:0] e,
                        input bit fault, input bit stray, input bit clr_at_check);
    logic [7:0] result;
    bit mism;
    @(negedge clk);
    addr_i = a; bit_i = b; exp_i = e; fault_en = fault; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    result = fault ? mem[a] : (mem[a] | (8'h1 << b));
    mism = (result != e);
    for (int n = 1; n <= TOTAL; n++) begin
      int ph = phase_at(n);
      check("R3 pins", {28'd0, ce_n_o, oe_n_o, pe_o, vsel_o}, {28'd0, pins_for(ph)});
      check("R4 pull", {24'd0, pull_lo_o}, (ph == 6) ? (32'h1 << b) : 32'd0);
      check("R7 done", {31'd0, done_o}, {31'd0, ph == 11});
      check("R2 R6 busy addr", {20'd0, busy_o, addr_o}, {20'd0, 1'b1, a});
      check("R9 reject held", {31'd0, reject_o}, {31'd0, rej_model});
      clr_rej_i = 1'b0;
      if (stray && (n == 5 || n == TOTAL)) begin start_i = 1'b1; addr_i = ~a; bit_i = ~b; end
      else start_i = 1'b0;
      if (clr_at_check && n == TOTAL) clr_rej_i = 1'b1;
      @(negedge clk);
    end
    start_i = 1'b0;
    clr_rej_i = 1'b0;
    rej_model = mism || (rej_model && !clr_at_check);
    check("R8 R9 reject after check", {31'd0, reject_o}, {31'd0, rej_model});
    check("R7 busy low", {30'd0, busy_o, done_o}, 32'd0);
    check("R10 R1 idle pins", {28'd0, ce_n_o, oe_n_o, pe_o, vsel_o}, 32'b1010);
    check("R10 addr kept", {21'd0, addr_o}, {21'd0, a});
  endtask

  task automatic clear_reject();
    @(negedge clk); clr_rej_i = 1'b1;
    @(negedge clk); clr_rej_i = 1'b0;
    rej_model = 1'b0;
    check("R9 clear", {31'd0, reject_o}, 32'd0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
      end
    join_none
    void'($urandom(32'd4242));
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 reset pins", {28'd0, ce_n_o, oe_n_o, pe_o, vsel_o}, 32'b1010);
    check("R1 reset flags", {21'd0, busy_o, done_o, reject_o, pull_lo_o}, 32'd0);
    check("R1 reset addr", {21'd0, addr_o}, 32'd0);
    rst_n = 1'b1;
    // Directed: pass, bit 0 and bit 7, top address.
    run_op(11'h7FF, 3'd0, 8'h01, 1'b0, 1'b0, 1'b0);
    run_op(11'h000, 3'd7, 8'h80, 1'b0, 1'b0, 1'b0);
    // Directed: fuse does not blow -> reject (R8), stray start (R10).
    run_op(11'h123, 3'd3, 8'h08, 1'b1, 1'b1, 1'b0);
    // Reject sticky across a passing op (R9).
    run_op(11'h124, 3'd2, 8'h04, 1'b0, 1'b0, 1'b0);
    clear_reject();
    // Mismatch with clear in same cycle: set wins (R9).
    run_op(11'h200, 3'd5, 8'hFF, 1'b0, 1'b0, 1'b1);
    // Clear during check of passing op clears (R9).
    run_op(11'h201, 3'd1, 8'h02, 1'b0, 1'b0, 1'b1);
    // Random operations.
    for (int k = 0; k < 30; k++) begin
      logic [10:0] a;
      logic [2:0]  b;
      logic [7:0]  e;
      bit f, s;
      a = 11'($urandom);
      b = 3'($urandom);
      f = ($urandom % 5) == 0;
      s = ($urandom % 3) == 0;
      e = (($urandom % 4) == 0) ? 8'($urandom) : (mem[a] | (8'h1 << b));
      run_op(a, b, e, f, s, ($urandom % 6) == 0);
      if (rej_model && (($urandom % 2) == 0)) clear_reject();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule